// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block steps through a display raster one pixel clock at a time and produces horizontal sync, vertical sync, a data-enable flag and the pixel and line coordinates of the visible area. Each line is cut into four segments in a fixed order: active video, front porch, sync pulse and back porch. Each frame is cut the same way, counted in lines. All eight segment lengths sit in registers that a simple write port loads while the raster runs.

Writes go to a pending bank. The pending bank is copied into the live bank, which drives the counters, only on the clock edge that ends a frame. A frame is therefore always built from one complete set of timing values. Reset values for both banks come from parameters. By default they describe a 1920 by 1080 raster with 2430 clocks per line and 1139 lines per frame, which gives about 16.36 µs per line and about 53.65 Hz per frame at a 148.5 MHz pixel clock.

Top module: `raster_timing_gen`

## Requirements
- R1: Each line runs through active video, then front porch, then sync, then back porch. The line is as many clocks long as the four horizontal lengths added together, and hsync is asserted exactly during the horizontal sync segment.
- R2: Each frame runs through the same four segments counted in whole lines. vsync is asserted for every clock of the lines in the vertical sync segment, and it changes only at a line start.
- R3: A write with `wr_en` high stores the 12-bit `wr_data` into a pending register at the clock edge. `wr_addr` selects the register: 0 horizontal active, 1 horizontal front porch, 2 horizontal sync, 3 horizontal back porch, 4 vertical active, 5 vertical front porch, 6 vertical sync, 7 vertical back porch.
- R4: Pending values reach the counters only at the edge that follows the last pixel of the last line of a frame. A frame in progress keeps its timing whatever is written during it.
- R5: `de` is high only when both the horizontal and the vertical position are inside their active segments. While `de` is high, neither sync is asserted.
- R6: `x` and `y` give the zero-based pixel and line inside the active area. `x` counts up by one per clock along a line, and both are zero whenever `de` is low.
- R7: The parameter `SYNC_HIGH` sets the sync polarity. With its default of 1, an asserted sync drives 1 and a deasserted sync drives 0.
- R8: While `rst` is high, `de` is low, both syncs are deasserted, `x` and `y` are zero, and both banks take the reset-value parameters.
- R9: Outputs are registered. The first clock edge after reset is released presents pixel 0 of line 0 of a frame.
- R10: A porch or sync length of zero removes that segment from the line or frame. The other segments keep their order and lengths. Each axis must total at least one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the timing registers |
| wr_addr | input | 3 | Timing register select |
| wr_data | input | 12 | Segment length to store |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-video flag |
| x | output | 12 | Pixel index inside the active area |
| y | output | 12 | Line index inside the active area |

## Verification
A corrupted horizontal counter appears within a single line: `x` skips or repeats a value, or hsync lands on the wrong clock. A corrupted vertical counter appears at the next line boundary as a wrong `y` or a misplaced vsync. A live bank that follows the pending bank too early changes the position of sync and `de` within the same frame the write arrived in. A bank that never loads keeps the old geometry through the whole next frame. A cycle-by-cycle scoreboard compares every output on every clock against an independent raster model, so each of these faults is caught on the first clock where the outputs differ.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Segment order inside one axis; the order is behaviour, not layout.
  localparam int SEGS = 4;
  localparam int AXES = 2;
  localparam int NREG = SEGS * AXES;

  typedef enum logic [1:0] {
    SEG_ACT   = 2'd0,
    SEG_FRONT = 2'd1,
    SEG_SYNC  = 2'd2,
    SEG_BACK  = 2'd3
  } seg_e;

  // Register address is {axis, segment}.
  typedef enum logic {
    AX_H = 1'b0,
    AX_V = 1'b1
  } axis_e;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 3,
  parameter logic [NREG-1:0][LEN_W-1:0] RST_SET = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [LEN_W-1:0]           wr_data,
  input  logic                       frame_load,
  output logic [NREG-1:0][LEN_W-1:0] live
);

  logic [NREG-1:0][LEN_W-1:0] pend;

  // Pending bank takes writes; live bank copies it only at frame end.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= RST_SET;
      live <= RST_SET;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && (wr_addr == ADDR_W'(i))) begin
          pend[i] <= wr_data;
        end
        if (frame_load) begin
          live[i] <= pend[i];
        end
      end
    end
  end

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = LEN_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic [SEGS-1:0][LEN_W-1:0] len,
  output logic [LEN_W-1:0]           pos,
  output logic                       last,
  output logic                       in_act,
  output logic                       in_sync
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] end_act;
  logic [CNT_W-1:0] end_front;
  logic [CNT_W-1:0] end_sync;
  logic [CNT_W-1:0] total;

  // Segment boundaries as running sums of the live lengths.
  always_comb begin
    end_act   = CNT_W'(len[SEG_ACT]);
    end_front = end_act   + CNT_W'(len[SEG_FRONT]);
    end_sync  = end_front + CNT_W'(len[SEG_SYNC]);
    total     = end_sync  + CNT_W'(len[SEG_BACK]);
  end

  assign last    = (cnt + CNT_W'(1)) >= total;
  assign in_act  = cnt < end_act;
  assign in_sync = (cnt >= end_front) && (cnt < end_sync);
  assign pos     = in_act ? cnt[LEN_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rtg_outreg.sv
module rtg_outreg #(
  parameter int LEN_W     = 12,
  parameter bit SYNC_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] h_pos,
  input  logic [LEN_W-1:0] v_pos,
  input  logic             h_act,
  input  logic             v_act,
  input  logic             h_sync,
  input  logic             v_sync,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [LEN_W-1:0] x,
  output logic [LEN_W-1:0] y
);

  logic de_nxt;
  assign de_nxt = h_act & v_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= ~SYNC_HIGH;
      vsync <= ~SYNC_HIGH;
      de    <= 1'b0;
      x     <= '0;
      y     <= '0;
    end else begin
      hsync <= h_sync ? SYNC_HIGH : ~SYNC_HIGH;
      vsync <= v_sync ? SYNC_HIGH : ~SYNC_HIGH;
      de    <= de_nxt;
      x     <= de_nxt ? h_pos : '0;
      y     <= de_nxt ? v_pos : '0;
    end
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int H_ACT     = 1920,
  parameter int H_FRONT   = 205,
  parameter int H_SYNC    = 50,
  parameter int H_BACK    = 255,
  parameter int V_ACT     = 1080,
  parameter int V_FRONT   = 2,
  parameter int V_SYNC    = 55,
  parameter int V_BACK    = 2,
  parameter bit SYNC_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [LEN_W-1:0] wr_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [LEN_W-1:0] x,
  output logic [LEN_W-1:0] y
);

  localparam int CNT_W  = LEN_W + 2;
  localparam int ADDR_W = $clog2(NREG);
  localparam logic [NREG-1:0][LEN_W-1:0] RST_SET = {
    LEN_W'(V_BACK), LEN_W'(V_SYNC), LEN_W'(V_FRONT), LEN_W'(V_ACT),
    LEN_W'(H_BACK), LEN_W'(H_SYNC), LEN_W'(H_FRONT), LEN_W'(H_ACT)
  };

  logic [NREG-1:0][LEN_W-1:0] live;
  logic [AXES-1:0][LEN_W-1:0] pos;
  logic [AXES-1:0]            last;
  logic [AXES-1:0]            in_act;
  logic [AXES-1:0]            in_sync;
  logic [AXES-1:0]            step;
  logic                       frame_load;

  assign step[AX_H] = 1'b1;
  assign step[AX_V] = last[AX_H];
  assign frame_load = last[AX_H] & last[AX_V];

  rtg_regs #(
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W),
    .RST_SET(RST_SET)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_load(frame_load),
    .live      (live)
  );

  // One counter per axis; the vertical one advances on horizontal wrap.
  generate
    for (genvar a = 0; a < AXES; a++) begin : g_axis
      rtg_axis #(
        .LEN_W(LEN_W),
        .CNT_W(CNT_W)
      ) u_axis (
        .clk    (clk),
        .rst    (rst),
        .step   (step[a]),
        .len    (live[a*SEGS +: SEGS]),
        .pos    (pos[a]),
        .last   (last[a]),
        .in_act (in_act[a]),
        .in_sync(in_sync[a])
      );
    end
  endgenerate

  rtg_outreg #(
    .LEN_W    (LEN_W),
    .SYNC_HIGH(SYNC_HIGH)
  ) u_out (
    .clk   (clk),
    .rst   (rst),
    .h_pos (pos[AX_H]),
    .v_pos (pos[AX_V]),
    .h_act (in_act[AX_H]),
    .v_act (in_act[AX_V]),
    .h_sync(in_sync[AX_H]),
    .v_sync(in_sync[AX_V]),
    .hsync (hsync),
    .vsync (vsync),
    .de    (de),
    .x     (x),
    .y     (y)
  );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter bit SYNC_HIGH = 1'b1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       hsync,
  input logic                       vsync,
  input logic                       de,
  input logic [LEN_W-1:0]           x,
  input logic [LEN_W-1:0]           y,
  input logic                       frame_load,
  input logic [NREG-1:0][LEN_W-1:0] live
);

  assert_blank_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !de |-> (x == '0 && y == '0));

  assert_x_steps_R6: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de) && x != '0) |-> (x == LEN_W'($past(x) + 1'b1) && y == $past(y)));

  assert_live_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_load |=> $stable(live));

  assert_vsync_line_start_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(vsync) |-> (x == '0));

  assert_no_sync_in_active_R5: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync != SYNC_HIGH && vsync != SYNC_HIGH));

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!de && x == '0 && y == '0 && hsync == !SYNC_HIGH && vsync == !SYNC_HIGH));

endmodule

bind raster_timing_gen rtg_checker #(
  .LEN_W    (LEN_W),
  .SYNC_HIGH(SYNC_HIGH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hsync     (hsync),
  .vsync     (vsync),
  .de        (de),
  .x         (x),
  .y         (y),
  .frame_load(frame_load),
  .live      (live)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [LW-1:0] wr_data = '0;
  logic          hsync, vsync, de;
  logic [LW-1:0] x, y;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen #(
    .LEN_W(LW),
    .H_ACT(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(2),
    .V_ACT(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(1)
  ) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y)
  );

  typedef struct {
    bit hs;
    bit vs;
    bit de;
    int x;
    int y;
    int phase;
  } exp_t;

  exp_t q[$];

  // Independent raster model: position plus live and pending length sets.
  int mh = 0, mv = 0;
  int lh[4] = '{8, 2, 3, 2};
  int lv[4] = '{4, 1, 2, 1};
  int ph[4] = '{8, 2, 3, 2};
  int pv[4] = '{4, 1, 2, 1};
  int phase = 0;

  function automatic string ptag(int p);
    case (p)
      0: return "R9";
      1: return "R3 R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int got, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, expv, $time);
    end
  endtask

  // Driver: predicts the outputs after the coming edge, then advances the model.
  task automatic step_model(bit we, int a, int d);
    exp_t e;
    int hb1, hb2, hb3, htot, vb1, vb2, vb3, vtot;
    bit ha, va;
    hb1 = lh[0]; hb2 = hb1 + lh[1]; hb3 = hb2 + lh[2]; htot = hb3 + lh[3];
    vb1 = lv[0]; vb2 = vb1 + lv[1]; vb3 = vb2 + lv[2]; vtot = vb3 + lv[3];
    ha = mh < hb1;
    va = mv < vb1;
    e.hs = (mh >= hb2) && (mh < hb3);
    e.vs = (mv >= vb2) && (mv < vb3);
    e.de = ha && va;
    e.x = e.de ? mh : 0;
    e.y = e.de ? mv : 0;
    e.phase = phase;
    q.push_back(e);
    if (mh == htot - 1) begin
      mh = 0;
      if (mv == vtot - 1) begin
        mv = 0;
        lh = ph;
        lv = pv;
      end else begin
        mv++;
      end
    end else begin
      mh++;
    end
    if (we) begin
      if (a < 4) ph[a] = d;
      else pv[a-4] = d;
    end
  endtask

  task automatic cycle(bit we, int a, int d);
    @(negedge clk);
    rst = 1'b0;
    wr_en = we;
    wr_addr = 3'(a);
    wr_data = LW'(d);
    step_model(we, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0);
  endtask

  // Monitor: compares each registered result just after its edge.
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        t = ptag(e.phase);
        chk(hsync == e.hs, {"hsync R1 R7 ", t}, int'(hsync), int'(e.hs));
        chk(vsync == e.vs, {"vsync R2 R7 ", t}, int'(vsync), int'(e.vs));
        chk(de == e.de,    {"de R5 ", t},       int'(de),    int'(e.de));
        chk(int'(x) == e.x, {"x R6 ", t},       int'(x),     e.x);
        chk(int'(y) == e.y, {"y R6 ", t},       int'(y),     e.y);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: state held while reset is high
    chk(de == 1'b0, "de R8", int'(de), 0);
    chk(hsync == 1'b0 && vsync == 1'b0, "sync R8 R7", int'({hsync, vsync}), 0);
    chk(x == '0 && y == '0, "xy R8", int'({x, y}), 0);

    // R9 R1 R2: two frames on the reset settings (15 x 8 = 120 clocks)
    phase = 0;
    idle(250);

    // R3 R4: new settings written mid-frame, applied at the next frame
    phase = 1;
    idle(17);
    cycle(1, 0, 6);
    cycle(1, 1, 1);
    cycle(1, 2, 2);
    cycle(1, 3, 3);
    cycle(1, 4, 3);
    cycle(1, 5, 2);
    cycle(1, 6, 1);
    cycle(1, 7, 2);
    idle(300);

    // R10: zero-length porches on both axes
    phase = 2;
    cycle(1, 0, 5);
    cycle(1, 1, 0);
    cycle(1, 2, 1);
    cycle(1, 3, 0);
    cycle(1, 4, 2);
    cycle(1, 5, 0);
    cycle(1, 6, 1);
    cycle(1, 7, 1);
    idle(200);

    @(posedge clk);
    #2;
    chk(q.size() == 0, "scoreboard drained R1", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 got=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule